// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block sits beside an SDR SDRAM command bus and only listens. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins, together with the bank address and A10. It keeps its own picture of each bank: idle, holding an open row, or closing after a precharge. It also tracks a device-wide refresh phase. Clock counts since the relevant earlier commands are kept with saturating counters.

Whenever a command breaks the state rules or comes too soon after an earlier command, the monitor raises a single-cycle `illegal` pulse with a 3-bit cause code. The live state of every bank is always shown on `bank_state`. The minimum intervals are parameters counted in clocks:

- activate to column access
- activate to precharge
- precharge to idle
- refresh duration
- activate to activate
- last write to precharge

A command that is flagged is treated as never issued. It changes no bank state and restarts no timer. Burst length, mode-register contents and stored data are not modelled. The final write data is taken to arrive in the same cycle as the write command.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are decoded from (cs_n, ras_n, cas_n, we_n) as follows:
  - cs_n=1 is deselect.
  - 0111 is NOP, 0110 is burst stop and 0011 is activate.
  - 0101 is read, 0100 is write and 0010 is precharge.
  - 0001 is refresh and 0000 is mode-register set.
  - A10=1 turns read and write into their auto-precharge forms and turns precharge into precharge-all.
  - Deselect, NOP and burst stop are never flagged and change nothing.
- R2: The result of a command sampled at edge t appears on `illegal`/`reason` after edge t+1 and lasts one cycle. `reason` is 0 whenever `illegal` is low. The cause codes are:
  - 1: the bank or device is in the wrong state.
  - 2: the activate-to-access interval was not met.
  - 3: the activate-to-precharge interval was not met.
  - 4: activate to an open bank.
  - 5: the activate-to-activate interval was not met.
  - 6: the device is refreshing.
  - 7: the write-to-precharge interval was not met.
- R3: A read or write (either form) to a bank that has no open row gives cause 1.
- R4: A read or write to an open bank fewer than T_RCD clocks after its activate gives cause 2. At exactly T_RCD clocks it is legal.
- R5: Precharge, or precharge-all, of an open bank fewer than T_RAS clocks after its activate gives cause 3. Precharge of an idle or closing bank is legal and has no effect.
- R6: Precharge of an open bank whose activate interval is met, but fewer than T_RWL clocks after its last write, gives cause 7. Precharge-all reports cause 3 before cause 7 and considers only open banks.
- R7: Activate to an open bank gives cause 4. Activate to a closing bank gives cause 1.
- R8: Activate to an idle bank fewer than T_RRD clocks after the last accepted activate (to any bank) gives cause 5.
- R9: An accepted precharge, auto-precharge read or auto-precharge write issued at edge t puts the bank in the closing state. The bank shows idle from edge t+T_RP. A bank never goes straight from idle to closing.
- R10: Refresh and mode-register set need every bank idle; otherwise they give cause 1. An accepted refresh at edge t shows every bank as refreshing until it shows idle from edge t+T_RC.
- R11: While refreshing, every command other than deselect, NOP and burst stop gives cause 6. Cause 6 is checked first for every command.
- R12: After reset all banks are idle, all intervals count as met and `illegal` is low. A flagged command changes no state and no timer.
- R13: `bank_state[2i+1:2i]` holds bank i's state: 0 idle, 1 open, 2 closing, 3 refreshing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, commands sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks select |
| illegal | output | 1 | One-cycle pulse for a rejected command |
| reason | output | 3 | Cause code of the pulse, 0 otherwise |
| bank_state | output | 2*2^BA_W | Per-bank state, two bits per bank |

## Verification
A wrong bank state or a wrong timer inside the monitor can stay hidden until a later command touches that bank. At that point it shows up on `illegal`/`reason` one clock after the command, as a spurious or missing pulse. A wrong state is also visible on `bank_state` right away. The bench therefore compares every port against a behavioural model on every clock, under both directed and random command streams. A state error is caught within one cycle of the state going wrong. A timer error is caught at the first command that tests that interval. The directed sequence places commands exactly one clock before and exactly on each interval boundary.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_DESL, CMD_NOP, CMD_BST, CMD_ACT,
    CMD_RD, CMD_RDA, CMD_WR, CMD_WRA,
    CMD_PRE, CMD_PALL, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_PRECH = 2'd2,
    BK_REFR  = 2'd3
  } bank_st_e;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_STATE   = 3'd1,
    RSN_RCD     = 3'd2,
    RSN_RAS     = 3'd3,
    RSN_REOPEN  = 3'd4,
    RSN_RRD     = 3'd5,
    RSN_REFBUSY = 3'd6,
    RSN_RWL     = 3'd7
  } reason_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_DESL;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_BST;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
        3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
        3'b010:  cmd = a10 ? CMD_PALL : CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdram_sat_timer.sv
module sdram_sat_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] elapsed
);

  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] elapsed_d;

  // elapsed = clocks since the last restart; saturates so "long ago" stays met
  always_comb begin
    elapsed_d = elapsed;
    if (restart)
      elapsed_d = CW'(1);
    else if (elapsed != SAT)
      elapsed_d = elapsed + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      elapsed <= SAT;
    else
      elapsed <= elapsed_d;
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int CW    = 4,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_RWL = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     open_req,
  input  logic     close_req,
  input  logic     wr_req,
  output bank_st_e state,
  output logic     rcd_ok,
  output logic     ras_ok,
  output logic     rwl_ok
);

  // closing ends when the next elapsed value reaches T_RP
  localparam int       PRE_LAST = (T_RP > 1) ? T_RP - 1 : 1;
  localparam bank_st_e CLOSE_ST = (T_RP > 1) ? BK_PRECH : BK_IDLE;

  logic [CW-1:0] act_el, wr_el, pre_el;
  bank_st_e      state_d;

  sdram_sat_timer #(.CW(CW)) act_tmr_i (
    .clk(clk), .rst_n(rst_n), .restart(open_req), .elapsed(act_el));

  sdram_sat_timer #(.CW(CW)) wr_tmr_i (
    .clk(clk), .rst_n(rst_n), .restart(wr_req), .elapsed(wr_el));

  sdram_sat_timer #(.CW(CW)) pre_tmr_i (
    .clk(clk), .rst_n(rst_n), .restart(close_req), .elapsed(pre_el));

  always_comb begin
    state_d = state;
    if (open_req)
      state_d = BK_OPEN;
    else if (close_req)
      state_d = CLOSE_ST;
    else if (state == BK_PRECH && pre_el >= CW'(PRE_LAST))
      state_d = BK_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= BK_IDLE;
    else
      state <= state_d;
  end

  assign rcd_ok = (act_el >= CW'(T_RCD));
  assign ras_ok = (act_el >= CW'(T_RAS));
  assign rwl_ok = (wr_el  >= CW'(T_RWL));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_RC  = 8,
  parameter int T_RRD = 2,
  parameter int T_RWL = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BA_W-1:0]           ba,
  input  logic                      a10,
  output logic                      illegal,
  output logic [2:0]                reason,
  output logic [2*(1<<BA_W)-1:0]    bank_state
);

  localparam int NB      = 1 << BA_W;
  localparam int M_A     = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int M_B     = (T_RP  > T_RC)  ? T_RP  : T_RC;
  localparam int M_C     = (T_RRD > T_RWL) ? T_RRD : T_RWL;
  localparam int M_AB    = (M_A > M_B) ? M_A : M_B;
  localparam int TMAX    = (M_AB > M_C) ? M_AB : M_C;
  localparam int CW      = $clog2(TMAX + 1);
  localparam int RC_LAST = (T_RC > 1) ? T_RC - 1 : 1;

  cmd_e          cmd;
  bank_st_e      bst [NB];
  logic [NB-1:0] sel, is_open, is_idle, is_prech;
  logic [NB-1:0] rcd_ok, ras_ok, rwl_ok;
  logic [NB-1:0] open_req, close_req, wr_req;
  logic [CW-1:0] rrd_el, ref_el;
  logic          refreshing, refreshing_d;
  logic          ok, act_go, ref_go, is_wr;
  reason_e       why;
  logic          illegal_q;
  reason_e       reason_q;

  sdram_cmd_decode dec_i (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .a10(a10), .cmd(cmd));

  assign sel = NB'(1) << ba;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    sdram_bank_track #(
      .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RWL(T_RWL)
    ) trk_i (
      .clk(clk), .rst_n(rst_n),
      .open_req(open_req[i]), .close_req(close_req[i]), .wr_req(wr_req[i]),
      .state(bst[i]),
      .rcd_ok(rcd_ok[i]), .ras_ok(ras_ok[i]), .rwl_ok(rwl_ok[i]));

    assign is_open[i]  = (bst[i] == BK_OPEN);
    assign is_idle[i]  = (bst[i] == BK_IDLE);
    assign is_prech[i] = (bst[i] == BK_PRECH);
    assign bank_state[2*i +: 2] = refreshing ? BK_REFR : bst[i];
  end

  // rule evaluation: refresh-busy first, then state, then intervals
  always_comb begin
    why = RSN_NONE;
    case (cmd)
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
        if (refreshing)        why = RSN_REFBUSY;
        else if (!is_open[ba]) why = RSN_STATE;
        else if (!rcd_ok[ba])  why = RSN_RCD;
      end
      CMD_ACT: begin
        if (refreshing)                 why = RSN_REFBUSY;
        else if (is_prech[ba])          why = RSN_STATE;
        else if (is_open[ba])           why = RSN_REOPEN;
        else if (rrd_el < CW'(T_RRD))   why = RSN_RRD;
      end
      CMD_PRE: begin
        if (refreshing) why = RSN_REFBUSY;
        else if (is_open[ba]) begin
          if (!ras_ok[ba])      why = RSN_RAS;
          else if (!rwl_ok[ba]) why = RSN_RWL;
        end
      end
      CMD_PALL: begin
        if (refreshing)                  why = RSN_REFBUSY;
        else if (|(is_open & ~ras_ok))   why = RSN_RAS;
        else if (|(is_open & ~rwl_ok))   why = RSN_RWL;
      end
      CMD_REF, CMD_MRS: begin
        if (refreshing)    why = RSN_REFBUSY;
        else if (!(&is_idle)) why = RSN_STATE;
      end
      default: why = RSN_NONE;
    endcase
  end

  assign ok     = (why == RSN_NONE);
  assign act_go = ok && (cmd == CMD_ACT);
  assign ref_go = ok && (cmd == CMD_REF);
  assign is_wr  = (cmd == CMD_WR) || (cmd == CMD_WRA);

  always_comb begin
    open_req  = act_go ? sel : '0;
    wr_req    = (ok && is_wr) ? sel : '0;
    close_req = '0;
    if (ok) begin
      case (cmd)
        CMD_PRE:          close_req = sel & is_open;
        CMD_PALL:         close_req = is_open;
        CMD_RDA, CMD_WRA: close_req = sel;
        default:          close_req = '0;
      endcase
    end
  end

  sdram_sat_timer #(.CW(CW)) rrd_tmr_i (
    .clk(clk), .rst_n(rst_n), .restart(act_go), .elapsed(rrd_el));

  sdram_sat_timer #(.CW(CW)) ref_tmr_i (
    .clk(clk), .rst_n(rst_n), .restart(ref_go), .elapsed(ref_el));

  always_comb begin
    refreshing_d = refreshing;
    if (ref_go)
      refreshing_d = (T_RC > 1);
    else if (refreshing && ref_el >= CW'(RC_LAST))
      refreshing_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refreshing <= 1'b0;
      illegal_q  <= 1'b0;
      reason_q   <= RSN_NONE;
    end else begin
      refreshing <= refreshing_d;
      illegal_q  <= !ok;
      reason_q   <= why;
    end
  end

  assign illegal = illegal_q;
  assign reason  = reason_q;

endmodule

// File: rtl/sdram_mon_checker.sv
module sdram_mon_checker #(
  parameter int BA_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   ras_n,
  input logic                   cas_n,
  input logic                   we_n,
  input logic [BA_W-1:0]        ba,
  input logic                   illegal,
  input logic [2:0]             reason,
  input logic [2*(1<<BA_W)-1:0] bank_state
);

  localparam int NB = 1 << BA_W;

  logic [1:0] cur_st;
  logic       is_col, is_act, is_busy_cmd;

  assign cur_st      = bank_state[{ba, 1'b0} +: 2];
  assign is_col      = !cs_n && ras_n && !cas_n;
  assign is_act      = !cs_n && !ras_n && cas_n && we_n;
  assign is_busy_cmd = !cs_n && !(ras_n && cas_n);

  p_reason_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> reason == 3'd0);

  p_reason_given_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> reason != 3'd0);

  p_desl_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !illegal);

  p_rw_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && (cur_st == 2'd0 || cur_st == 2'd2)) |=> (illegal && reason == 3'd1));

  p_reopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && cur_st == 2'd1) |=> (illegal && reason == 3'd4));

  p_refbusy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_busy_cmd && bank_state[1:0] == 2'd3) |=> (illegal && reason == 3'd6));

  for (genvar i = 0; i < NB; i++) begin : g_chk
    p_refresh_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state[1:0] == 2'd3) == (bank_state[2*i +: 2] == 2'd3));

    p_no_idle_to_prech_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state[2*i +: 2] == 2'd0) |=> (bank_state[2*i +: 2] != 2'd2));
  end

endmodule

bind sdram_cmd_monitor sdram_mon_checker #(.BA_W(BA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .illegal(illegal), .reason(reason),
  .bank_state(bank_state));

// File: tb/sdram_cmd_monitor_tb_top.sv
module sdram_cmd_monitor_tb_top;

  localparam int BA_W = 2;
  localparam int NB   = 4;
  localparam int TRCD = 3, TRAS = 6, TRP = 3, TRC = 8, TRRD = 2, TRWL = 2;

  localparam int K_DESL = 0, K_NOP = 1, K_BST = 2, K_ACT = 3, K_RD = 4,
                 K_RDA = 5, K_WR = 6, K_WRA = 7, K_PRE = 8, K_PALL = 9,
                 K_REF = 10, K_MRS = 11;

  logic clk, rst_n, cs_n, ras_n, cas_n, we_n, a10;
  logic [BA_W-1:0] ba;
  logic illegal;
  logic [2:0] reason;
  logic [2*NB-1:0] bank_state;

  int total, bad;

  // behavioural reference state
  int st [NB];
  int e_act [NB];
  int e_wr [NB];
  int e_pre [NB];
  bit refr;
  int e_ref, e_rrd;
  int exp_reason;
  logic [2*NB-1:0] exp_bs;

  sdram_cmd_monitor #(
    .BA_W(BA_W), .T_RCD(TRCD), .T_RAS(TRAS), .T_RP(TRP),
    .T_RC(TRC), .T_RRD(TRRD), .T_RWL(TRWL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .illegal(illegal), .reason(reason),
    .bank_state(bank_state));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog expired: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic drive(int c, int b);
    logic [3:0] p;
    cs_n = 1'b0; a10 = 1'($urandom); ba = BA_W'(b);
    case (c)
      K_DESL: begin cs_n = 1'b1; p = 4'($urandom); ras_n = p[0]; cas_n = p[1]; we_n = p[2]; end
      K_NOP:  {ras_n, cas_n, we_n} = 3'b111;
      K_BST:  {ras_n, cas_n, we_n} = 3'b110;
      K_ACT:  {ras_n, cas_n, we_n} = 3'b011;
      K_RD:   begin {ras_n, cas_n, we_n} = 3'b101; a10 = 1'b0; end
      K_RDA:  begin {ras_n, cas_n, we_n} = 3'b101; a10 = 1'b1; end
      K_WR:   begin {ras_n, cas_n, we_n} = 3'b100; a10 = 1'b0; end
      K_WRA:  begin {ras_n, cas_n, we_n} = 3'b100; a10 = 1'b1; end
      K_PRE:  begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b0; end
      K_PALL: begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b1; end
      K_REF:  {ras_n, cas_n, we_n} = 3'b001;
      default: {ras_n, cas_n, we_n} = 3'b000;
    endcase
  endtask

  task automatic model(int c, int b);
    int r;
    r = 0;
    if (c != K_DESL && c != K_NOP && c != K_BST && refr) r = 6;
    else if (c == K_RD || c == K_RDA || c == K_WR || c == K_WRA) begin
      if (st[b] != 1) r = 1;
      else if (e_act[b] < TRCD) r = 2;
    end else if (c == K_ACT) begin
      if (st[b] == 2) r = 1;
      else if (st[b] == 1) r = 4;
      else if (e_rrd < TRRD) r = 5;
    end else if (c == K_PRE) begin
      if (st[b] == 1 && e_act[b] < TRAS) r = 3;
      else if (st[b] == 1 && e_wr[b] < TRWL) r = 7;
    end else if (c == K_PALL) begin
      for (int i = 0; i < NB; i++) if (st[i] == 1 && e_act[i] < TRAS) r = 3;
      if (r == 0)
        for (int i = 0; i < NB; i++) if (st[i] == 1 && e_wr[i] < TRWL) r = 7;
    end else if (c == K_REF || c == K_MRS) begin
      for (int i = 0; i < NB; i++) if (st[i] != 0) r = 1;
    end
    if (r == 0) begin
      if (c == K_ACT) begin st[b] = 1; e_act[b] = 0; e_rrd = 0; end
      if (c == K_WR || c == K_WRA) e_wr[b] = 0;
      if (c == K_RDA || c == K_WRA || (c == K_PRE && st[b] == 1)) begin
        st[b] = 2; e_pre[b] = 0;
      end
      if (c == K_PALL)
        for (int i = 0; i < NB; i++) if (st[i] == 1) begin st[i] = 2; e_pre[i] = 0; end
      if (c == K_REF) begin refr = 1; e_ref = 0; end
    end
    for (int i = 0; i < NB; i++) begin
      e_act[i]++; e_wr[i]++; e_pre[i]++;
      if (st[i] == 2 && e_pre[i] >= TRP) st[i] = 0;
    end
    e_ref++; e_rrd++;
    if (refr && e_ref >= TRC) refr = 0;
    exp_reason = r;
    for (int i = 0; i < NB; i++) exp_bs[2*i +: 2] = refr ? 2'd3 : 2'(st[i]);
  endtask

  task automatic step(int c, int b, string tag);
    drive(c, b);
    @(posedge clk);
    model(c, b);
    @(negedge clk);
    total++;
    if (illegal !== (exp_reason != 0) || reason !== 3'(exp_reason) || bank_state !== exp_bs) begin
      bad++;
      $display("FAIL %s cmd=%0d bank=%0d: actual ill=%b rsn=%0d st=%h expected ill=%0d rsn=%0d st=%h",
               tag, c, b, illegal, reason, bank_state, exp_reason != 0, exp_reason, exp_bs);
    end
  endtask

  task automatic want(int r, string tag);
    total++;
    if (reason !== 3'(r) || illegal !== (r != 0)) begin
      bad++;
      $display("FAIL %s directed cause: actual=%0d expected=%0d", tag, reason, r);
    end
  endtask

  task automatic want_st(int b, int s, string tag);
    total++;
    if (bank_state[2*b +: 2] !== 2'(s)) begin
      bad++;
      $display("FAIL %s bank %0d state: actual=%0d expected=%0d", tag, b, bank_state[2*b +: 2], s);
    end
  endtask

  initial begin
    int c;
    total = 0; bad = 0;
    rst_n = 1'b0;
    drive(K_NOP, 0);
    for (int i = 0; i < NB; i++) begin
      st[i] = 0; e_act[i] = 1000; e_wr[i] = 1000; e_pre[i] = 1000;
    end
    refr = 0; e_ref = 1000; e_rrd = 1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    total++;
    if (illegal !== 1'b0 || reason !== 3'd0 || bank_state !== '0) begin
      bad++;
      $display("FAIL R12 reset: actual ill=%b st=%h expected ill=0 st=0", illegal, bank_state);
    end

    step(K_RD, 0, "R3");   want(1, "R3");
    step(K_ACT, 0, "R13"); want(0, "R13"); want_st(0, 1, "R13");
    step(K_ACT, 1, "R8");  want(5, "R8");  want_st(1, 0, "R12");
    step(K_RD, 0, "R4");   want(2, "R4");
    step(K_RD, 0, "R4");   want(0, "R4");
    step(K_ACT, 0, "R7");  want(4, "R7");
    step(K_PRE, 0, "R5");  want(3, "R5");
    step(K_WR, 0, "R4");   want(0, "R4");
    step(K_PRE, 0, "R6");  want(7, "R6");
    step(K_PRE, 0, "R9");  want(0, "R9");  want_st(0, 2, "R9");
    step(K_ACT, 0, "R7");  want(1, "R7");  want_st(0, 2, "R9");
    step(K_NOP, 0, "R9");  want_st(0, 0, "R9");
    step(K_ACT, 0, "R9");  want(0, "R9");
    step(K_PRE, 2, "R5");  want(0, "R5");  want_st(2, 0, "R5");
    step(K_REF, 0, "R10"); want(1, "R10");
    step(K_MRS, 0, "R10"); want(1, "R10");
    step(K_NOP, 0, "R1");
    step(K_NOP, 0, "R1");
    step(K_PALL, 0, "R5"); want(0, "R5");  want_st(0, 2, "R9");
    step(K_REF, 0, "R10"); want(1, "R10");
    step(K_NOP, 0, "R1");  want_st(0, 0, "R9");
    step(K_REF, 0, "R10"); want(0, "R10"); want_st(3, 3, "R10");
    step(K_RD, 0, "R11");  want(6, "R11");
    step(K_ACT, 1, "R11"); want(6, "R11");
    step(K_NOP, 0, "R11"); want(0, "R11");
    step(K_BST, 0, "R11"); want(0, "R11");
    step(K_NOP, 0, "R10");
    step(K_NOP, 0, "R10"); want_st(0, 3, "R10");
    step(K_NOP, 0, "R10"); want_st(0, 0, "R10");
    step(K_MRS, 0, "R10"); want(0, "R10");
    step(K_ACT, 2, "R9");
    step(K_DESL, 2, "R1"); want(0, "R1");
    step(K_DESL, 2, "R1"); want(0, "R1");
    step(K_NOP, 2, "R1");
    step(K_RDA, 2, "R9");  want(0, "R9");  want_st(2, 2, "R9");
    step(K_ACT, 3, "R8");
    step(K_NOP, 0, "R1");
    step(K_NOP, 0, "R1");
    step(K_WRA, 3, "R6");  want(0, "R6");  want_st(3, 2, "R9");

    // random stream, compared each clock against the model
    for (int n = 0; n < 4000; n++) begin
      c = int'($urandom_range(0, 19));
      if (c > 11) c = (c > 15) ? K_NOP : K_DESL;
      step(c, int'($urandom_range(0, NB - 1)), "R12");
    end

    summary();
    $finish;
  end

endmodule